// File: doc/BRIEF.md
# Rotated-Byte Immediate Encoder and Expander

This block decides whether a data word can be written as a short byte rotated right by an even number of bit positions. If it can, the block produces the compact code for it: a rotate field in the upper bits and the byte in the lower bits. If no such form exists, the block marks the word as unencodable. An assembler-side or code-generation datapath uses it to choose between a single-instruction constant and a fallback sequence.

The encoder works serially. A start pulse captures the word. The block then tests one rotate-field value per clock, in ascending order from zero, and stops at the first value that fits. It signals completion with a one-cycle done pulse, and the result stays on the outputs until the next accepted start. A separate expander path is purely combinational and turns any code back into the full word. Start and done are plain control pins with no back-pressure. The result has no ready input, so a consumer must take it while it is held, which lasts until it launches the next start. A start that arrives while a scan is running is dropped.

The word width, byte width and rotate-field width are parameters. The rotation step is the word width divided by the number of rotate-field values, which is 2 with the defaults of 32, 8 and 4.

Top module: `rotimm_codec`

## Requirements
- R1: While reset is held and after its release, busy, done and invalid are 0 and enc_out is all zeros.
- R2: dec_out equals the low field dec_in[BYTE_W-1:0], zero-extended to DATA_W bits and rotated right by STEP times the rotate field dec_in[ROT_W+BYTE_W-1:BYTE_W], where STEP = DATA_W / 2^ROT_W. This path has no clock delay.
- R3: For an encodable word, enc_out = {r, n} with invalid = 0. Here r is the smallest rotate value for which the word rotated left by STEP*r fits in BYTE_W bits, and n is that rotated word. The value zero gives r = 0 and n = 0.
- R4: Count the clock edge that accepts start as edge 0. For a word that matches at rotate value r, done is high for exactly one cycle after edge r+1.
- R5: For a word with no matching rotate value, done is high for one cycle after edge 2^ROT_W, with invalid = 1 and enc_out all zeros.
- R6: A start asserted while busy is high has no effect on the running scan, its result or its timing.
- R7: busy is high from the cycle after an accepted start up to the done cycle, and it is low in the done cycle.
- R8: enc_out and invalid change only in a done cycle, and they hold their values until the next result.
- R9: For every encodable word, feeding enc_out back into dec_in gives dec_out equal to the original word.
- R10: With default parameters: 256 encodes as 12'hC01 (rotate 12, byte 1), 484 as 12'hF79, and 0x06000000 as 12'h406. The values 511, 370 and 0x06010000 are unencodable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan of value_in; ignored while busy |
| value_in | input | DATA_W | Word to encode, sampled with an accepted start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| invalid | output | 1 | Last word had no encoding |
| enc_out | output | ROT_W+BYTE_W | {rotate field, byte}; zero when invalid |
| dec_in | input | ROT_W+BYTE_W | Code for the expander |
| dec_out | output | DATA_W | Expanded word |

## Verification
The bench builds two copies. The first uses the default 32/8/4 parameters. On it the bench checks all 4096 expander codes, the specific constants named in R10, the start-while-busy and hold cases, and rotated bytes chosen at random. The second copy uses an 8-bit word, a 4-bit byte and a 2-bit rotate field. That size makes every one of the 256 input words reachable, so the search order, the first-match rule, the latency for each rotate value and the invalid timing are covered exhaustively against arithmetic expectations.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_e;
endpackage

// File: rtl/rotimm_rot.sv
// Barrel rotator; LEFT picks the direction. W must be a power of two so the
// index arithmetic wraps modulo W on its own.
module rotimm_rot #(
  parameter int W    = 32,
  parameter int SW   = $clog2(W),
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SW-1:0] IDX = SW'(i);
    if (LEFT) begin : g_l
      assign dout[i] = din[IDX - amt];
    end else begin : g_r
      assign dout[i] = din[IDX + amt];
    end
  end
endmodule

// File: rtl/rotimm_probe.sv
// Tests one rotate value: undoes the rotation and checks the byte fits.
module rotimm_probe #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] value,
  input  logic [ROT_W-1:0]  rot,
  output logic              hit,
  output logic [BYTE_W-1:0] lit
);
  localparam int SW     = $clog2(DATA_W);
  localparam int STEP_W = $clog2(DATA_W >> ROT_W);

  logic [SW-1:0]     amt;
  logic [DATA_W-1:0] undone;

  assign amt = SW'(rot) << STEP_W;

  rotimm_rot #(.W(DATA_W), .SW(SW), .LEFT(1'b1)) u_rol (
    .din (value),
    .amt (amt),
    .dout(undone)
  );

  assign hit = (undone[DATA_W-1:BYTE_W] == '0);
  assign lit = undone[BYTE_W-1:0];
endmodule

// File: rtl/rotimm_ctrl.sv
// Scan sequencer: steps the rotate index from zero until a hit or the end.
module rotimm_ctrl
  import rotimm_pkg::*;
#(
  parameter int ROT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  output logic             busy,
  output logic             accept,
  output logic             finish,
  output logic [ROT_W-1:0] rot_idx
);
  scan_e            st_q;
  logic [ROT_W-1:0] idx_q;
  logic             at_last;

  assign at_last = &idx_q;
  assign busy    = (st_q == SCAN_RUN);
  assign accept  = start && (st_q == SCAN_IDLE);
  assign finish  = busy && (hit || at_last);
  assign rot_idx = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SCAN_IDLE;
      idx_q <= '0;
    end else if (accept) begin
      st_q  <= SCAN_RUN;
      idx_q <= '0;
    end else if (finish) begin
      st_q  <= SCAN_IDLE;
    end else if (busy) begin
      idx_q <= idx_q + ROT_W'(1);
    end
  end
endmodule

// File: rtl/rotimm_dec.sv
// Combinational expander: byte zero-extended, rotated right by STEP*field.
module rotimm_dec #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [ROT_W+BYTE_W-1:0] code,
  output logic [DATA_W-1:0]       value
);
  localparam int SW     = $clog2(DATA_W);
  localparam int STEP_W = $clog2(DATA_W >> ROT_W);

  logic [DATA_W-1:0] wide;
  logic [SW-1:0]     amt;

  assign wide = {{(DATA_W-BYTE_W){1'b0}}, code[BYTE_W-1:0]};
  assign amt  = SW'(code[ROT_W+BYTE_W-1:BYTE_W]) << STEP_W;

  rotimm_rot #(.W(DATA_W), .SW(SW), .LEFT(1'b0)) u_ror (
    .din (wide),
    .amt (amt),
    .dout(value)
  );
endmodule

// File: rtl/rotimm_codec.sv
module rotimm_codec #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DATA_W-1:0]       value_in,
  output logic                    busy,
  output logic                    done,
  output logic                    invalid,
  output logic [ROT_W+BYTE_W-1:0] enc_out,
  input  logic [ROT_W+BYTE_W-1:0] dec_in,
  output logic [DATA_W-1:0]       dec_out
);
  localparam int ENC_W = ROT_W + BYTE_W;

  logic [DATA_W-1:0] value_q;
  logic              accept, finish, hit;
  logic [ROT_W-1:0]  rot_idx;
  logic [BYTE_W-1:0] lit;
  logic              done_q, inv_q;
  logic [ENC_W-1:0]  enc_q;

  rotimm_ctrl #(.ROT_W(ROT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .hit    (hit),
    .busy   (busy),
    .accept (accept),
    .finish (finish),
    .rot_idx(rot_idx)
  );

  rotimm_probe #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_probe (
    .value(value_q),
    .rot  (rot_idx),
    .hit  (hit),
    .lit  (lit)
  );

  rotimm_dec #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_dec (
    .code (dec_in),
    .value(dec_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
      enc_q   <= '0;
    end else begin
      if (accept) value_q <= value_in;
      done_q <= finish;
      if (finish) begin
        inv_q <= !hit;
        enc_q <= hit ? {rot_idx, lit} : '0;
      end
    end
  end

  assign done    = done_q;
  assign invalid = inv_q;
  assign enc_out = enc_q;
endmodule

// File: rtl/rotimm_codec_chk.sv
module rotimm_codec_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [DATA_W-1:0]       value_in,
  input logic                    busy,
  input logic                    done,
  input logic                    invalid,
  input logic [ROT_W+BYTE_W-1:0] enc_out
);
  localparam int ENC_W = ROT_W + BYTE_W;
  localparam int STEP  = DATA_W >> ROT_W;
  localparam logic [ROT_W:0] LIMIT = (ROT_W+1)'(1 << ROT_W);

  logic [DATA_W-1:0] cap_q;
  logic [ROT_W:0]    age_q;

  function automatic logic [DATA_W-1:0] expand(input logic [ENC_W-1:0] c);
    logic [DATA_W-1:0] x;
    logic [DATA_W-1:0] res;
    int sh;
    x = '0;
    x[BYTE_W-1:0] = c[BYTE_W-1:0];
    sh = int'(c[ENC_W-1:BYTE_W]) * STEP;
    for (int i = 0; i < DATA_W; i++) res[i] = x[(i + sh) % DATA_W];
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
      age_q <= '0;
    end else if (start && !busy) begin
      cap_q <= value_in;
      age_q <= '0;
    end else if (busy) begin
      age_q <= age_q + (ROT_W+1)'(1);
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> age_q <= LIMIT);
  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R5
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> enc_out == '0);
  // R9
  roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid) |-> expand(enc_out) == cap_q);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(enc_out) && $stable(invalid)));
endmodule

bind rotimm_codec rotimm_codec_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .value_in(value_in),
  .busy    (busy),
  .done    (done),
  .invalid (invalid),
  .enc_out (enc_out)
);

// File: tb/sim_rotimm_codec.sv
`timescale 1ns/1ps
module sim_rotimm_codec;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;

  // default build
  logic        s0;
  logic [31:0] v0;
  logic        b0, d0, i0;
  logic [11:0] e0, di0;
  logic [31:0] do0;
  // small build: 8-bit word, 4-bit byte, 2-bit rotate field
  logic        s1;
  logic [7:0]  v1;
  logic        b1, d1, i1;
  logic [5:0]  e1, di1;
  logic [7:0]  do1;

  int total = 0;
  int bad   = 0;

  rotimm_codec u0 (
    .clk(clk), .rst_n(rst_n), .start(s0), .value_in(v0), .busy(b0),
    .done(d0), .invalid(i0), .enc_out(e0), .dec_in(di0), .dec_out(do0)
  );

  rotimm_codec #(.DATA_W(8), .BYTE_W(4), .ROT_W(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start(s1), .value_in(v1), .busy(b1),
    .done(d1), .invalid(i1), .enc_out(e1), .dec_in(di1), .dec_out(do1)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_enc(input logic [63:0] v, input int w, input int bw,
                                  input int nr, output bit ok, output int r,
                                  output logic [63:0] n);
    logic [63:0] mask;
    logic [63:0] rl;
    int s;
    mask = (64'd1 << w) - 64'd1;
    ok = 1'b0; r = 0; n = '0;
    for (int rr = nr - 1; rr >= 0; rr--) begin
      s  = rr * (w / nr);
      rl = ((v << s) | (v >> (w - s))) & mask;
      if (rl < (64'd1 << bw)) begin ok = 1'b1; r = rr; n = rl; end
    end
  endfunction

  function automatic logic [63:0] ref_dec(input logic [63:0] n, input int r,
                                          input int w, input int nr);
    logic [63:0] mask;
    int s;
    mask = (64'd1 << w) - 64'd1;
    s = r * (w / nr);
    return ((n >> s) | (n << (w - s))) & mask;
  endfunction

  task automatic enc0(input logic [31:0] v);
    bit ok; int r; logic [63:0] n; int k; int expk;
    ref_enc({32'd0, v}, 32, 8, 16, ok, r, n);
    @(negedge clk); v0 = v; s0 = 1'b1;
    @(negedge clk); s0 = 1'b0; k = 1;
    chk(b0 == 1'b1, "R7 busy after start", {63'd0, b0}, 64'd1);
    while (!d0 && k < 40) begin @(negedge clk); k++; end
    expk = ok ? r + 2 : 17;
    chk(k == expk, ok ? "R4 latency" : "R5 latency", k, expk);
    chk(b0 == 1'b0, "R7 busy low at done", {63'd0, b0}, 64'd0);
    if (ok) chk(i0 == 1'b0 && e0 == {r[3:0], n[7:0]}, "R3 code", {i0, e0}, {r[3:0], n[7:0]});
    else    chk(i0 == 1'b1 && e0 == '0, "R5 invalid", {i0, e0}, 13'h1000);
    di0 = e0; #1;
    if (ok) chk(do0 == v, "R9 round trip", do0, v);
  endtask

  task automatic enc1(input logic [7:0] v);
    bit ok; int r; logic [63:0] n; int k; int expk;
    ref_enc({56'd0, v}, 8, 4, 4, ok, r, n);
    @(negedge clk); v1 = v; s1 = 1'b1;
    @(negedge clk); s1 = 1'b0; k = 1;
    chk(b1 == 1'b1, "R7 busy after start", {63'd0, b1}, 64'd1);
    while (!d1 && k < 20) begin @(negedge clk); k++; end
    expk = ok ? r + 2 : 5;
    chk(k == expk, ok ? "R4 latency" : "R5 latency", k, expk);
    chk(b1 == 1'b0, "R7 busy low at done", {63'd0, b1}, 64'd0);
    if (ok) chk(i1 == 1'b0 && e1 == {r[1:0], n[3:0]}, "R3 code", {i1, e1}, {r[1:0], n[3:0]});
    else    chk(i1 == 1'b1 && e1 == '0, "R5 invalid", {i1, e1}, 7'h40);
    di1 = e1; #1;
    if (ok) chk(do1 == v, "R9 round trip", do1, v);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s0 = 1'b0; s1 = 1'b0; v0 = '0; v1 = '0; di0 = '0; di1 = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({b0, d0, i0, e0} == '0, "R1 reset u0", {b0, d0, i0, e0}, 0);
    chk({b1, d1, i1, e1} == '0, "R1 reset u1", {b1, d1, i1, e1}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({b0, d0, i0, e0} == '0, "R1 after release", {b0, d0, i0, e0}, 0);

    // R2: every code of both builds
    for (int c = 0; c < 4096; c++) begin
      di0 = c[11:0]; #1;
      chk(do0 == ref_dec({56'd0, c[7:0]}, c / 256, 32, 16), "R2 expand u0",
          do0, ref_dec({56'd0, c[7:0]}, c / 256, 32, 16));
    end
    for (int c = 0; c < 64; c++) begin
      di1 = c[5:0]; #1;
      chk(do1 == ref_dec({60'd0, c[3:0]}, c / 16, 8, 4), "R2 expand u1",
          do1, ref_dec({60'd0, c[3:0]}, c / 16, 8, 4));
    end

    // R10 named constants
    enc0(32'd256);        chk(e0 == 12'hC01 && !i0, "R10 256", e0, 12'hC01);
    enc0(32'd484);        chk(e0 == 12'hF79 && !i0, "R10 484", e0, 12'hF79);
    enc0(32'h06000000);   chk(e0 == 12'h406 && !i0, "R10 0x06000000", e0, 12'h406);
    enc0(32'd511);        chk(i0 == 1'b1, "R10 511", i0, 1);
    enc0(32'd370);        chk(i0 == 1'b1, "R10 370", i0, 1);
    enc0(32'h06010000);   chk(i0 == 1'b1, "R10 0x06010000", i0, 1);
    enc0(32'd0);          chk(e0 == 12'h000 && !i0, "R3 zero", e0, 0);
    enc0(32'hF000000F);
    enc0(32'hFFFFFFFF);
    enc0(32'h000000FF);

    // R6: start held high with another word while the scan of 256 runs
    @(negedge clk); v0 = 32'd256; s0 = 1'b1;
    @(negedge clk); v0 = 32'd1;
    begin
      int k;
      k = 1;
      while (!d0 && k < 40) begin
        @(negedge clk); k++;
        if (k == 5) s0 = 1'b0;
      end
      chk(k == 14, "R6 timing unaffected", k, 14);
      chk(e0 == 12'hC01 && !i0, "R6 result unaffected", e0, 12'hC01);
    end
    // R8: result holds while idle and value_in moves
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); v0 = 32'h12345678 + j;
      chk(e0 == 12'hC01 && !d0 && !i0, "R8 hold", {d0, e0}, 12'hC01);
    end

    // rotated bytes and raw words on the default build
    for (int j = 0; j < 40; j++) begin
      int r; logic [63:0] n;
      n = 64'($urandom_range(0, 255));
      r = int'($urandom_range(0, 15));
      enc0(ref_dec(n, r, 32, 16));
    end
    for (int j = 0; j < 20; j++) enc0($urandom);

    // exhaustive on the small build
    for (int v = 0; v < 256; v++) enc1(v[7:0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule